// File: doc/BRIEF.md
# Multiplexed Pixel Port Unpacker

This block takes a 64-bit word from a video-memory pixel bus and turns it into a stream of single pixels, one per pixel-clock cycle. A 2-bit mode input sets the pixel depth, and the depth fixes how many pixels come out of each word: eight 8-bit pixels, four 16-bit pixels, two 32-bit pixels, or one 64-bit value. Pixels leave starting at the lowest-numbered bit lanes of the word. A run-time control input can reverse the byte order inside every pixel-sized group, so that memory holding big-endian data still produces correct pixels.

The whole block runs on the pixel clock. It drives a load clock toward the memory. That clock is the pixel clock divided by the active multiplex ratio, so the memory can place the next word on the bus in time. The block samples a word on the pixel-clock edge that ends the last pixel of the previous word. A change of the mode input is only acted on at a word boundary. The new mode costs two idle cycles, during which the valid strobe stays low.

Top module: `pix_unpacker`

## Requirements
- R1: While reset is asserted, and in the cycle right after it, pix_valid is 0. While reset is asserted, load_clk and pix_out are also 0.
- R2: With mode_sel 0 (8 bits per pixel), each captured word yields eight pixels in consecutive cycles, taken from bits 7:0, then 15:8, and so on up to 63:56.
- R3: With mode_sel 1 (16 bits per pixel), each word yields four pixels, taken from bits 15:0, 31:16, 47:32 and then 63:48.
- R4: With mode_sel 2 (32 bits per pixel), each word yields two pixels, bits 31:0 first and then 63:32.
- R5: With mode_sel 3 (64-bit direct), each word yields one 64-bit value, and back-to-back words in this mode give valid on every cycle.
- R6: When big_endian is 1 at the capture edge, the byte order inside each pixel-sized group of the word is reversed, and the order of the groups stays the same. In 8-bit mode the bit has no effect on the output.
- R7: In the cycle that carries pixel i (counted from 0) of a word at ratio r, load_clk is 1 exactly when (i+1) mod r >= r/2. In 1:1 mode load_clk stays 1 while words stream.
- R8: The active mode changes only at a word boundary. A new mode_sel value applied partway through a word leaves the remaining pixels of that word unchanged.
- R9: When the mode differs from that of the previous word, exactly two cycles with pix_valid low separate the last pixel of the old mode from the first pixel of the new mode. With the mode unchanged, no such gap appears.
- R10: pix_out holds the pixel in its low bits, with the width set by mode_sel (0: 8, 1: 16, 2: 32, 3: 64 bits). All higher bits are 0 while pix_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Pixel depth / multiplex ratio select (0: 8:1, 1: 4:1, 2: 2:1, 3: 1:1) |
| big_endian | input | 1 | 1 reverses the byte order inside each pixel, sampled at capture |
| pix_word | input | 64 | Word from the video-memory pixel bus |
| load_clk | output | 1 | Load clock toward memory, pixel clock divided by the ratio |
| pix_out | output | 64 | Current pixel, right-aligned, upper bits zero |
| pix_valid | output | 1 | pix_out carries a pixel this cycle |

## Verification
A word counter that has drifted shows up within one word period. The load_clk pattern no longer matches the pixel index, and pixels come from the wrong lanes or the next word is captured at the wrong time. A wrong active mode or byte-swap setting corrupts the first pixel of the affected word, so the scoreboard reports it in the very next valid cycle. An error in mode changes shows in the count of idle cycles between two words, or as a wrong pixel in the word that was serializing while mode_sel moved.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int PORT_W = 64;
    localparam int LANE_W = 8;
    localparam int LANES  = PORT_W / LANE_W;
    localparam int CNT_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        M_8  = 2'd0,
        M_16 = 2'd1,
        M_32 = 2'd2,
        M_64 = 2'd3
    } pxmode_t;

    typedef enum logic {
        ST_ADOPT = 1'b0,
        ST_RUN   = 1'b1
    } seq_st_t;

    typedef struct packed {
        logic              valid;
        logic [PORT_W-1:0] data;
    } pix_t;

    // pixels per word for a mode
    function automatic logic [CNT_W:0] mode_ratio(input pxmode_t m);
        return (CNT_W+1)'(LANES >> m);
    endfunction

    // pixel width in bits for a mode
    function automatic int mode_bits(input pxmode_t m);
        return LANE_W << m;
    endfunction

    function automatic logic [PORT_W-1:0] pix_mask(input pxmode_t m);
        if (m == M_64) return '1;
        return (PORT_W'(1) << mode_bits(m)) - PORT_W'(1);
    endfunction

    function automatic logic [PORT_W-1:0] drop_pix(input logic [PORT_W-1:0] x,
                                                   input pxmode_t m);
        if (m == M_64) return '0;
        return x >> mode_bits(m);
    endfunction

    // byte reversal inside each pixel-sized group
    function automatic logic [PORT_W-1:0] swap_groups(input logic [PORT_W-1:0] w,
                                                      input pxmode_t m,
                                                      input logic be);
        logic [PORT_W-1:0] r;
        int gb;
        int off;
        int src;
        r  = w;
        gb = 1 << m;
        if (be) begin
            for (int b = 0; b < LANES; b++) begin
                off = b % gb;
                src = (b - off) + (gb - 1 - off);
                r[b*LANE_W +: LANE_W] = w[src*LANE_W +: LANE_W];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pxu_seq.sv
module pxu_seq
    import pxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pxmode_t          mode_req,
    output pxmode_t          mode_act,
    output logic [CNT_W-1:0] cnt_o,
    output logic             capture,
    output logic             advance,
    output logic             load_clk
);

    seq_st_t          st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   ratio;
    logic [CNT_W:0]   cnt_nx;

    assign ratio   = mode_ratio(mode_act);
    assign cnt_nx  = {1'b0, cnt} + 1'b1;
    assign capture = (st == ST_RUN) && (cnt == '0) && (mode_req == mode_act);
    assign advance = (st == ST_RUN) && ((cnt != '0) || capture);
    assign load_clk = (st == ST_RUN) && ({1'b0, cnt} >= (ratio >> 1));
    assign cnt_o   = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_ADOPT;
            cnt      <= '0;
            mode_act <= M_8;
        end else begin
            case (st)
                ST_ADOPT: begin
                    mode_act <= mode_req;
                    cnt      <= '0;
                    st       <= ST_RUN;
                end
                default: begin
                    if ((cnt == '0) && !capture) begin
                        st <= ST_ADOPT;
                    end else if (advance) begin
                        cnt <= (cnt_nx == ratio) ? '0 : cnt_nx[CNT_W-1:0];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pxu_order.sv
module pxu_order
    import pxu_pkg::*;
(
    input  logic [PORT_W-1:0] word_in,
    input  pxmode_t           mode,
    input  logic              be,
    output logic [PORT_W-1:0] word_out
);

    always_comb begin
        word_out = swap_groups(word_in, mode, be);
    end

endmodule

// File: rtl/pxu_shift.sv
module pxu_shift
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              advance,
    input  pxmode_t           mode,
    input  logic [PORT_W-1:0] word_ord,
    output pix_t              pix
);

    logic [PORT_W-1:0] shreg;
    logic [PORT_W-1:0] mask;

    assign mask = pix_mask(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            pix   <= '0;
        end else begin
            pix.valid <= advance;
            if (capture) begin
                pix.data <= word_ord & mask;
                shreg    <= drop_pix(word_ord, mode);
            end else if (advance) begin
                pix.data <= shreg & mask;
                shreg    <= drop_pix(shreg, mode);
            end
        end
    end

endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              big_endian,
    input  logic [PORT_W-1:0] pix_word,
    output logic              load_clk,
    output logic [PORT_W-1:0] pix_out,
    output logic              pix_valid
);

    pxmode_t           mode_act;
    logic [CNT_W-1:0]  cnt;
    logic              capture;
    logic              advance;
    logic [PORT_W-1:0] word_ord;
    pix_t              pix;

    pxu_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_req (pxmode_t'(mode_sel)),
        .mode_act (mode_act),
        .cnt_o    (cnt),
        .capture  (capture),
        .advance  (advance),
        .load_clk (load_clk)
    );

    pxu_order u_order (
        .word_in  (pix_word),
        .mode     (mode_act),
        .be       (big_endian),
        .word_out (word_ord)
    );

    pxu_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .advance  (advance),
        .mode     (mode_act),
        .word_ord (word_ord),
        .pix      (pix)
    );

    assign pix_out   = pix.data;
    assign pix_valid = pix.valid;

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker
    import pxu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input pxmode_t           mode_act,
    input logic [CNT_W-1:0]  cnt,
    input logic              capture,
    input logic              load_clk,
    input logic              pix_valid,
    input logic [PORT_W-1:0] pix_out
);

    // R8: active mode moves only after a word boundary
    a_r8_mode_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_act) |-> ($past(cnt) == '0));

    // R9: the adoption cycle never carries a pixel
    a_r9_idle_on_adopt: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_act) |-> !pix_valid);

    // R10: bits above the pixel width are clear
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && (mode_act != M_64)) |-> ((pix_out >> mode_bits(mode_act)) == '0));

    // R5: in 1:1 the load clock is high at every capture
    a_r5_direct_lclk: assert property (@(posedge clk) disable iff (rst)
        (capture && (mode_act == M_64)) |-> load_clk);

    // R7: the word counter stays below the ratio
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} < mode_ratio(mode_act)));

endmodule

bind pix_unpacker pxu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_act  (mode_act),
    .cnt       (cnt),
    .capture   (capture),
    .load_clk  (load_clk),
    .pix_valid (pix_valid),
    .pix_out   (pix_out)
);

// File: tb/sim_pix_unpacker.sv
`timescale 1ns/1ps
module sim_pix_unpacker;

    typedef struct packed {
        logic [63:0] pix;
        logic        first;
        logic        lclk;
        logic        chk_gap;
        logic [1:0]  gap;
        logic [1:0]  mode;
        logic        be;
    } exp_t;

    localparam int NJ = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'd0;
    logic        big_endian = 1'b0;
    logic [63:0] pix_word = '0;
    logic        load_clk;
    logic [63:0] pix_out;
    logic        pix_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int next_job = 0;
    int gap_cnt = 0;
    bit all_done = 0;
    bit running = 0;

    logic [63:0] job_word [NJ];
    logic [1:0]  job_mode [NJ];
    logic        job_be   [NJ];
    exp_t        q[$];

    always #2.5 clk = ~clk;

    pix_unpacker u0 (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .big_endian (big_endian),
        .pix_word   (pix_word),
        .load_clk   (load_clk),
        .pix_out    (pix_out),
        .pix_valid  (pix_valid)
    );

    function automatic logic [63:0] exp_order(input logic [63:0] w, input int m, input bit be);
        logic [63:0] r;
        int gb;
        r  = w;
        gb = 1 << m;
        if (be) begin
            for (int g = 0; g < 8 / gb; g++) begin
                for (int j = 0; j < gb; j++) begin
                    r[(g*gb + j)*8 +: 8] = w[(g*gb + gb - 1 - j)*8 +: 8];
                end
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: present a job on the bus and queue its expected pixels
    task automatic present_job(input int k);
        int m;
        int r;
        int w;
        logic [63:0] ord;
        logic [63:0] mask;
        exp_t e;
        m = int'(job_mode[k]);
        r = 8 >> m;
        w = 8 << m;
        mode_sel   = job_mode[k];
        big_endian = job_be[k];
        pix_word   = job_word[k];
        ord  = exp_order(job_word[k], m, job_be[k]);
        mask = (m == 3) ? '1 : ((64'd1 << w) - 64'd1);
        for (int i = 0; i < r; i++) begin
            e.pix     = (ord >> (i * w)) & mask;
            e.first   = (i == 0);
            e.lclk    = (((i + 1) % r) >= (r / 2));
            e.chk_gap = (i == 0) && (k > 0);
            e.gap     = (k > 0 && job_mode[k] != job_mode[k-1]) ? 2'd2 : 2'd0;
            e.mode    = job_mode[k];
            e.be      = job_be[k];
            q.push_back(e);
        end
    endtask

    // monitor: compare at the falling edge
    initial begin
        exp_t e;
        string tag;
        forever begin
            @(negedge clk);
            if (running && !all_done) begin
                if (pix_valid) begin
                    if (q.size() == 0) begin
                        all_done = 1;
                    end else begin
                        e = q.pop_front();
                        case (e.mode)
                            2'd0: tag = e.be ? "R2 R6 R10" : "R2 R10";
                            2'd1: tag = e.be ? "R3 R6 R10" : "R3 R10";
                            2'd2: tag = e.be ? "R4 R6 R10" : "R4 R10";
                            default: tag = e.be ? "R5 R6" : "R5";
                        endcase
                        check({tag, " R8 pixel"}, pix_out, e.pix);
                        check("R7 load_clk", {63'd0, load_clk}, {63'd0, e.lclk});
                        if (e.first && e.chk_gap)
                            check("R9 idle gap", 64'(gap_cnt), {62'd0, e.gap});
                        gap_cnt = 0;
                        if (e.first && next_job < NJ) begin
                            present_job(next_job);
                            next_job++;
                        end
                        if (q.size() == 0 && next_job >= NJ) all_done = 1;
                    end
                end else begin
                    gap_cnt++;
                end
            end
        end
    end

    initial begin
        int cyc;
        // job list: modes and ordering switch between words
        for (int k = 0; k < NJ; k++) begin
            job_word[k] = {8'(8*k+8), 8'(8*k+7), 8'(8*k+6), 8'(8*k+5),
                           8'(8*k+4), 8'(8*k+3), 8'(8*k+2), 8'(8*k+1)} ^ (64'hA5 << (k % 8) * 8);
        end
        job_mode[0]  = 2'd0; job_be[0]  = 1'b0;
        job_mode[1]  = 2'd0; job_be[1]  = 1'b1;
        job_mode[2]  = 2'd1; job_be[2]  = 1'b0;
        job_mode[3]  = 2'd1; job_be[3]  = 1'b1;
        job_mode[4]  = 2'd2; job_be[4]  = 1'b0;
        job_mode[5]  = 2'd2; job_be[5]  = 1'b1;
        job_mode[6]  = 2'd3; job_be[6]  = 1'b0;
        job_mode[7]  = 2'd3; job_be[7]  = 1'b1;
        job_mode[8]  = 2'd3; job_be[8]  = 1'b0;
        job_mode[9]  = 2'd0; job_be[9]  = 1'b0;
        job_mode[10] = 2'd3; job_be[10] = 1'b1;
        job_mode[11] = 2'd1; job_be[11] = 1'b1;
        job_mode[12] = 2'd2; job_be[12] = 1'b0;
        job_mode[13] = 2'd0; job_be[13] = 1'b1;

        present_job(0);
        next_job = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {63'd0, pix_valid}, 64'd0);
        check("R1 reset load_clk", {63'd0, load_clk}, 64'd0);
        check("R1 reset pix_out", pix_out, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, pix_valid}, 64'd0);
        running = 1;

        cyc = 0;
        while (!all_done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!all_done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion, %0d items left",
                     cyc, q.size());
        end
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule